// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command front end of a parallel NOR flash array whose lowest region is a boot sector that can be locked. It watches bus write cycles formed by an active-low chip enable and an active-low write enable. It decodes multi-cycle unlock sequences into five kinds of operation: program, sector erase, chip erase, boot lockout, and entering or leaving identification mode. It then runs an embedded operation whose length is set by a cycle counter. When the counter runs out, it either commits one word write or requests a range erase from an external array model.

The array has four regions, listed from low to high address: a boot sector of `BOOT_WORDS` words, two parameter regions of `PARAM_WORDS` words each, and a main region that runs up to the top address. Every program and erase is gated against the lockout bit. A single digital override input stands for the high-voltage lockout bypass, and it counts only if it is held for the whole operation. Reset aborts any running operation, leaves identification mode, returns to plain reads and clears the lockout bit, because reset here models power-up.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A program sequence takes four write cycles: (UA1, AAh), (UA2, 55h), (UA1, A0h), then (target, value). After the operation the word at the target holds the new value.
- R2: Programming only clears bits. The stored word becomes the old word ANDed with the written value, and bits already at 0 stay at 0.
- R3: A sector erase takes six write cycles: (UA1, AAh), (UA2, 55h), (UA1, 80h), (UA1, AAh), (UA2, 55h), then (any address inside the region, 30h). Every word of that one region becomes all ones, and the other regions keep their contents.
- R4: The six-cycle chip erase ends with (UA1, 10h). With the lockout clear, it sets every word of the array to all ones.
- R5: The six-cycle lockout sequence ends with (UA1, 40h). After it, a program or sector erase aimed at the boot sector has no effect on the array unless the override is used.
- R6: A chip erase issued while the lockout is set clears the parameter and main regions and leaves the boot sector unchanged.
- R7: If the override input is high from the start of an operation to its end, a boot-sector program goes ahead despite the lockout. If the override is low at any point in between, the boot sector is left unchanged.
- R8: Identification mode is entered with (UA1, AAh), (UA2, 55h), (UA1, 90h). In that mode a read at boot offset 2 returns the lockout bit on data bit 0, with 1 meaning locked. The sequence ending in F0h leaves the mode, after which the same read returns array data.
- R9: Every write cycle that ends while the controller is busy is ignored, including a complete program sequence.
- R10: A wrong address or data value at any step of a sequence returns the decoder to read mode with no side effect. A target write that follows a broken sequence changes nothing and does not start an operation.
- R11: Reset aborts a running operation before it commits. It clears busy and leaves the target word unchanged.
- R12: Busy rises on the clock after the last write cycle of a program or erase sequence and stays high for exactly `OP_CYCLES` cycles.
- R13: The address is taken when the write cycle starts, that is, when the later of the two enables goes low. The data is taken when the cycle ends, that is, when the first of the two enables goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, modelling power-up |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | AW | Bus address for command cycles |
| bus_wdata | input | DW | Bus write data; bits above 7 are ignored in command codes |
| hv_override | input | 1 | Lockout bypass, must be held for the whole operation |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data (array word, or lockout bit in identification mode) |
| busy | output | 1 | Embedded operation running |
| arr_addr | output | AW | Array address: the operation target while busy, otherwise rd_addr |
| arr_rdata | input | DW | Array word at arr_addr |
| arr_wr | output | 1 | One-cycle word write strobe |
| arr_wdata | output | DW | Word to write (old AND new) |
| arr_erase | output | 1 | One-cycle range erase strobe |
| erase_lo | output | AW | First word of the erase range |
| erase_hi | output | AW | Last word of the erase range |

## Verification
The bench builds the block with an 8-bit address and 8-bit data. The boot sector is 32 words and each parameter region is 16 words, so the regions span 0–31, 32–47, 48–63 and 64–255. The unlock addresses are 55h and AAh, and `OP_CYCLES` is 40. These values make the whole array small enough to compare word for word after every erase. An operation is still long enough that a complete four-cycle program sequence, a mid-operation reset, or a dropped override all fit inside one busy window.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int BOOT_WORDS = 8192,
  parameter int PARAM_WORDS = 4096,
  parameter int OP_CYCLES = 1000,
  parameter logic [AW-1:0] UA1 = AW'('h5555),
  parameter logic [AW-1:0] UA2 = AW'('h2AAA)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ce_n,
  input  logic          bus_we_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          hv_override,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_rdata,
  output logic          arr_wr,
  output logic [DW-1:0] arr_wdata,
  output logic          arr_erase,
  output logic [AW-1:0] erase_lo,
  output logic [AW-1:0] erase_hi
);
  localparam logic [AW-1:0] P1_BASE   = AW'(BOOT_WORDS);
  localparam logic [AW-1:0] P2_BASE   = AW'(BOOT_WORDS + PARAM_WORDS);
  localparam logic [AW-1:0] MAIN_BASE = AW'(BOOT_WORDS + 2 * PARAM_WORDS);
  localparam logic [AW-1:0] TOP       = {AW{1'b1}};
  localparam logic [AW-1:0] ID_ADDR   = AW'(2);
  localparam int CW = $clog2(OP_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3} st_t;
  st_t st;

  logic act, act_q, wr_end;
  logic [AW-1:0] cap_addr;
  logic [7:0] code;
  logic idmode, locked, ovr_ok;
  logic op_prog, op_chip, op_boot;
  logic [AW-1:0] op_addr, op_lo, op_hi;
  logic [DW-1:0] op_data;
  logic [CW-1:0] cnt;
  logic done, allowed, at1, at2, start_prog, start_erase;
  logic [AW-1:0] sec_lo, sec_hi;

  assign act    = !bus_ce_n && !bus_we_n;
  assign wr_end = act_q && !act;
  assign code   = bus_wdata[7:0];
  assign at1    = cap_addr == UA1;
  assign at2    = cap_addr == UA2;

  assign start_prog  = wr_end && !busy && st == S_PGM;
  assign start_erase = wr_end && !busy && st == S_E3 &&
                       ((at1 && code == 8'h10) || code == 8'h30);

  always_comb begin
    if (cap_addr < P1_BASE)        begin sec_lo = '0;        sec_hi = P1_BASE - 1'b1;   end
    else if (cap_addr < P2_BASE)   begin sec_lo = P1_BASE;   sec_hi = P2_BASE - 1'b1;   end
    else if (cap_addr < MAIN_BASE) begin sec_lo = P2_BASE;   sec_hi = MAIN_BASE - 1'b1; end
    else                           begin sec_lo = MAIN_BASE; sec_hi = TOP;              end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q <= 1'b0;
      cap_addr <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q) cap_addr <= bus_addr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      idmode <= 1'b0;
      locked <= 1'b0;
    end else if (wr_end && !busy) begin
      st <= S_IDLE;
      case (st)
        S_IDLE: if (at1 && code == 8'hAA) st <= S_U1;
        S_U1:   if (at2 && code == 8'h55) st <= S_U2;
        S_U2: if (at1) begin
          if (code == 8'hA0) st <= S_PGM;
          if (code == 8'h80) st <= S_E1;
          if (code == 8'h90) idmode <= 1'b1;
          if (code == 8'hF0) idmode <= 1'b0;
        end
        S_E1: if (at1 && code == 8'hAA) st <= S_E2;
        S_E2: if (at2 && code == 8'h55) st <= S_E3;
        S_E3: if (at1 && code == 8'h40) locked <= 1'b1;
        default: ;
      endcase
    end

  assign done = busy && cnt == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      cnt <= '0;
      ovr_ok <= 1'b0;
      op_prog <= 1'b0;
      op_chip <= 1'b0;
      op_boot <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      op_lo <= '0;
      op_hi <= '0;
    end else if (start_prog || start_erase) begin
      busy <= 1'b1;
      cnt <= CW'(OP_CYCLES - 1);
      ovr_ok <= hv_override;
      op_prog <= start_prog;
      op_chip <= start_erase && code == 8'h10;
      op_boot <= cap_addr < P1_BASE;
      op_addr <= cap_addr;
      op_data <= bus_wdata;
      op_lo <= sec_lo;
      op_hi <= sec_hi;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      ovr_ok <= ovr_ok && hv_override;
      if (done) busy <= 1'b0;
    end

  assign allowed   = !locked || (ovr_ok && hv_override);
  assign arr_addr  = busy ? op_addr : rd_addr;
  assign arr_wdata = arr_rdata & op_data;
  assign arr_wr    = done && op_prog && (!op_boot || allowed);
  assign arr_erase = done && !op_prog && (op_chip || !op_boot || allowed);
  assign erase_lo  = op_chip ? (allowed ? '0 : P1_BASE) : op_lo;
  assign erase_hi  = op_chip ? TOP : op_hi;
  assign rd_data   = (idmode && rd_addr == ID_ADDR) ? DW'(locked) : arr_rdata;

  // R9
  always_ff @(posedge clk)
    if (rst_n) busy_idle_chk: assert (!busy || st == S_IDLE)
      else $error("decoder advanced while busy");

  // R12
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |=> busy && cnt == $past(cnt) - 1'b1);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R7
  boot_write_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr && arr_addr < P1_BASE && locked |-> hv_override);

  // R6
  chip_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase && locked && !hv_override |-> erase_lo >= P1_BASE);

  // R12
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr || arr_erase |=> !busy);
endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int AW = 8, DW = 8, OPC = 40, N = 256;
  localparam logic [7:0] A1 = 8'h55, A2 = 8'hAA;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, ovr = 0;
  logic [AW-1:0] addr = '0, rd_addr = '0, arr_addr, erase_lo, erase_hi;
  logic [DW-1:0] wdata = '0, rd_data, arr_rdata, arr_wdata;
  logic busy, arr_wr, arr_erase;
  logic [DW-1:0] mem [N];
  logic [DW-1:0] exp_m [N];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .DW(DW), .BOOT_WORDS(32), .PARAM_WORDS(16),
    .OP_CYCLES(OPC), .UA1(A1), .UA2(A2)) uut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_wdata(wdata), .hv_override(ovr),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_wr(arr_wr),
    .arr_wdata(arr_wdata), .arr_erase(arr_erase),
    .erase_lo(erase_lo), .erase_hi(erase_hi));

  assign arr_rdata = mem[arr_addr];
  always @(posedge clk) begin
    if (arr_wr) mem[arr_addr] <= arr_wdata;
    if (arr_erase)
      for (int i = 0; i < N; i++)
        if (i >= erase_lo && i <= erase_hi) mem[i] <= '1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R13: address valid only at cycle start, data valid only at cycle end
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = ~d; ce_n = 0; we_n = 0;
    @(negedge clk); addr = ~a; wdata = d;
    @(negedge clk); we_n = 1; ce_n = 1;
  endtask

  task automatic pre3(input logic [7:0] c);
    wr(A1, 8'hAA); wr(A2, 8'h55); wr(A1, c);
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d);
    pre3(8'hA0); wr(a, d);
  endtask

  task automatic erase6(input logic [7:0] a, input logic [7:0] c);
    pre3(8'h80); wr(A1, 8'hAA); wr(A2, 8'h55); wr(a, c);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  function automatic logic [7:0] region_lo(input int a);
    return a < 32 ? 8'd0 : a < 48 ? 8'd32 : a < 64 ? 8'd48 : 8'd64;
  endfunction
  function automatic int region_hi(input int a);
    return a < 32 ? 31 : a < 48 ? 47 : a < 64 ? 63 : 255;
  endfunction

  task automatic cmp_all(input string req);
    int bad = 0, first = -1;
    logic [7:0] v;
    for (int i = 0; i < N; i++) begin
      rd(i[7:0], v);
      if (v !== exp_m[i] && first < 0) first = i;
      if (v !== exp_m[i]) bad++;
    end
    chk(req, bad, 0);
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] v, a, d;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      mem[i] = 8'($urandom);
      exp_m[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 reset busy", busy, 0);
    rd(8'd70, v); chk("R11 reset read", v, exp_m[70]);

    // R1 R2 R12 R13 random programming
    for (int k = 0; k < 12; k++) begin
      a = 8'(64 + $urandom_range(0, 191));
      d = 8'($urandom);
      prog(a, d);
      wait_idle(n);
      exp_m[a] &= d;
      if (k == 0) chk("R12 busy length", n, OPC);
      rd(a, v); chk("R1 R2 R13 program", v, exp_m[a]);
    end
    // R2 bits stay cleared
    prog(8'd100, 8'h0F); wait_idle(n); exp_m[100] &= 8'h0F;
    prog(8'd100, 8'hF0); wait_idle(n); exp_m[100] &= 8'hF0;
    rd(8'd100, v); chk("R2 no set by program", v, 8'h00);

    // R3 sector erase parameter 1 via address 40
    erase6(8'd40, 8'h30); wait_idle(n);
    chk("R12 erase busy length", n, OPC);
    for (int i = 32; i < 48; i++) exp_m[i] = 8'hFF;
    cmp_all("R3 sector erase");
    // R3 sector erase main
    a = 8'($urandom_range(64, 255));
    erase6(a, 8'h30); wait_idle(n);
    for (int i = region_lo(a); i <= region_hi(a); i++) exp_m[i] = 8'hFF;
    cmp_all("R3 sector erase main");

    // R10 broken sequences
    wr(A1, 8'hAA); wr(A2, 8'h56); wr(A1, 8'hA0); wr(8'd33, 8'h00);
    #1 chk("R10 no busy", busy, 0);
    wr(A1, 8'hAA); wr(8'h54, 8'h55); wr(A1, 8'hA0); wr(8'd34, 8'h00);
    erase6(8'd40, 8'h31); #1 chk("R10 bad erase code", busy, 0);
    cmp_all("R10 no side effect");

    // R4 chip erase unlocked
    erase6(A1, 8'h10); wait_idle(n);
    for (int i = 0; i < N; i++) exp_m[i] = 8'hFF;
    cmp_all("R4 chip erase");

    // boot data and main data before lock
    prog(8'd5, 8'h3C); wait_idle(n); exp_m[5] = 8'h3C;
    prog(8'd200, 8'h11); wait_idle(n); exp_m[200] = 8'h11;

    // R8 identification mode
    pre3(8'h90);
    rd(8'd2, v); chk("R8 id unlocked", v, 8'h00);
    erase6(A1, 8'h40); #1 chk("R5 lock no busy", busy, 0);
    rd(8'd2, v); chk("R8 id locked", v, 8'h01);
    pre3(8'hF0);
    rd(8'd2, v); chk("R8 id exit", v, exp_m[2]);

    // R5 locked boot program and sector erase
    prog(8'd5, 8'h00); wait_idle(n);
    rd(8'd5, v); chk("R5 locked program", v, 8'h3C);
    erase6(8'd10, 8'h30); wait_idle(n);
    rd(8'd5, v); chk("R5 locked sector erase", v, 8'h3C);

    // R6 chip erase with lock spares boot
    erase6(A1, 8'h10); wait_idle(n);
    for (int i = 32; i < N; i++) exp_m[i] = 8'hFF;
    cmp_all("R6 locked chip erase");

    // R7 override held
    ovr = 1;
    prog(8'd5, 8'h0C); wait_idle(n); exp_m[5] = 8'h0C;
    ovr = 0;
    rd(8'd5, v); chk("R7 override held", v, 8'h0C);
    // R7 override dropped mid-operation
    ovr = 1;
    prog(8'd5, 8'h00);
    repeat (10) @(negedge clk);
    ovr = 0;
    repeat (5) @(negedge clk);
    ovr = 1;
    wait_idle(n); ovr = 0;
    rd(8'd5, v); chk("R7 override dropped", v, 8'h0C);

    // R9 commands while busy ignored
    prog(8'd80, 8'h0F);
    prog(8'd81, 8'h00);
    wait_idle(n); exp_m[80] = 8'h0F;
    rd(8'd81, v); chk("R9 ignored during busy", v, 8'hFF);
    rd(8'd80, v); chk("R9 first program done", v, 8'h0F);

    // R11 reset mid-operation
    prog(8'd90, 8'h00);
    repeat (5) @(negedge clk);
    rst_n = 0;
    @(negedge clk); #1 chk("R11 busy cleared", busy, 0);
    rst_n = 1;
    repeat (OPC + 5) @(negedge clk);
    rd(8'd90, v); chk("R11 target untouched", v, 8'hFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule